// File: doc/BRIEF.md
# Self-Routing Butterfly Switch Fabric

This block is a packet fabric with `PORTS` inputs and `PORTS` outputs. It is built as a butterfly of log2(`PORTS`) columns, and each column holds `PORTS`/2 two-by-two switching elements. Every packet is a single flit. It enters on an input stream with valid/ready handshaking and carries the number of the output it is heading for. On entry the fabric forms a routing tag, the exclusive-or of the source number and the destination number. Each column then reads one bit of that tag. A bit of 0 sends the flit along the straight edge and a bit of 1 sends it along the cross edge. The flit therefore follows the only path that joins its source to its destination.

Each element has an output register on both of its outputs. If both inputs of an element ask for the same output in the same cycle, a per-element round-robin bit picks the one that moves. The other input sees ready low and keeps its flit. Backpressure from a stalled output passes back through full registers to the inputs. At the far side, every output presents the payload together with the number of the input that sent it.

Top module: `bfly_net`

## Requirements
- R1: After reset is released and two further clock edges have passed, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: A flit accepted on input s with destination d leaves on output d with `out_src` equal to s and its payload unchanged.
- R3: Column c (c = 0 first) pairs lines whose indices differ only in bit log2(`PORTS`)-1-c, and it crosses when that bit of s XOR d is 1. Inputs 0 and 1 heading to outputs 1 and 0 are both accepted in the same cycle.
- R4: A flit meeting no contention and no stall leaves exactly log2(`PORTS`) clock edges after the edge that accepts it. No other output is valid while it is in flight.
- R5: When two flits ask for the same element output, one is accepted and the other input sees ready low in that cycle. `in_ready` is never low unless a flit is present at an input or inside the fabric.
- R6: Arbitration alternates. After a reset, the first clash at an element goes to its lower line, and each clash that moves a flit hands priority to the other line.
- R7: While `out_valid` is high and `out_ready` is low, that output keeps valid high and holds its payload and source stable.
- R8: With the destination stalled, one source can place exactly log2(`PORTS`) flits on its path, after which its `in_ready` is low. The flits then leave in the order they were accepted.
- R9: Under concurrent random traffic with random output stalls, no flit is lost or duplicated, and flits from one source to one destination keep their order.
- R10: The number of flits inside the fabric never exceeds `PORTS`·log2(`PORTS`) and is never smaller than the number of outputs showing valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | PORTS | Flit offered on each input |
| in_ready | output | PORTS | Input flit accepted at the next edge when valid is also high |
| in_dst | input | PORTS x log2(PORTS) | Destination output number per input |
| in_data | input | PORTS x DATA_W | Payload per input |
| out_valid | output | PORTS | Flit present on each output |
| out_ready | input | PORTS | Downstream accepts the output flit |
| out_data | output | PORTS x DATA_W | Payload per output |
| out_src | output | PORTS x log2(PORTS) | Input number the flit came from |

## Verification
If a column decodes the wrong tag bit or an element swaps its lines, the flit leaves on the wrong output or carries a wrong `out_src`. The bench flags this on the very edge of delivery, log2(`PORTS`) cycles after acceptance. A broken output register or a broken ready path shows up either as a delivery at the wrong cycle in the single-flit runs or as a ready bit that differs from the model in the clash and stall runs. Lost or doubled flits in the random run show up as an unexpected arrival or as a non-empty scoreboard after the drain. A stuck round-robin bit shows up at the ports as the wrong input winning the second clash.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  // priority holder of a 2x2 element: lower or upper line
  typedef enum logic {PRI_LO = 1'b0, PRI_HI = 1'b1} prio_e;

  // index of the lower line of element e in a column that splits on bit b
  function automatic int lo_line(input int e, input int b);
    return ((e >> b) << (b + 1)) | (e & ((1 << b) - 1));
  endfunction
endpackage

// File: rtl/bfly_elem.sv
module bfly_elem
  import bfly_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int BIT    = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             in_vld,
  output logic [1:0]             in_rdy,
  input  logic [1:0][DATA_W-1:0] in_data,
  input  logic [1:0][ADDR_W-1:0] in_tag,
  output logic [1:0]             out_vld,
  input  logic [1:0]             out_rdy,
  output logic [1:0][DATA_W-1:0] out_data,
  output logic [1:0][ADDR_W-1:0] out_tag
);
  logic [1:0]             want;
  logic [1:0]             take;
  logic [1:0]             fire;
  logic [1:0]             load;
  logic [1:0]             from_hi;
  logic [1:0]             vld_q, vld_d;
  logic [1:0][DATA_W-1:0] data_q, data_d;
  logic [1:0][ADDR_W-1:0] tag_q, tag_d;
  logic                   clash;
  prio_e                  rr_q, rr_d;

  always_comb begin
    // output wanted: own line index bit flipped by the tag bit
    want[0] = in_tag[0][BIT];
    want[1] = ~in_tag[1][BIT];
    clash   = in_vld[0] & in_vld[1] & (want[0] == want[1]);
    for (int o = 0; o < 2; o++) begin
      take[o] = ~vld_q[o] | out_rdy[o];
    end
    in_rdy[0] = take[want[0]] & ~(clash & (rr_q == PRI_HI));
    in_rdy[1] = take[want[1]] & ~(clash & (rr_q == PRI_LO));
    fire = in_vld & in_rdy;
    rr_d = rr_q;
    if (clash && (fire != 2'b00)) begin
      rr_d = (rr_q == PRI_LO) ? PRI_HI : PRI_LO;
    end
    for (int o = 0; o < 2; o++) begin
      from_hi[o] = fire[1] & (want[1] == o[0]);
      load[o]    = from_hi[o] | (fire[0] & (want[0] == o[0]));
      data_d[o]  = from_hi[o] ? in_data[1] : in_data[0];
      tag_d[o]   = from_hi[o] ? in_tag[1]  : in_tag[0];
      vld_d[o]   = load[o] | (vld_q[o] & ~out_rdy[o]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 2'b00;
      rr_q  <= PRI_LO;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < 2; o++) begin
      if (load[o]) begin
        data_q[o] <= data_d[o];
        tag_q[o]  <= tag_d[o];
      end
    end
  end

  assign out_vld  = vld_q;
  assign out_data = data_q;
  assign out_tag  = tag_q;
endmodule

// File: rtl/bfly_stage.sv
module bfly_stage
  import bfly_pkg::*;
#(
  parameter int PORTS  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int BIT    = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PORTS-1:0]             in_vld,
  output logic [PORTS-1:0]             in_rdy,
  input  logic [PORTS-1:0][DATA_W-1:0] in_data,
  input  logic [PORTS-1:0][ADDR_W-1:0] in_tag,
  output logic [PORTS-1:0]             out_vld,
  input  logic [PORTS-1:0]             out_rdy,
  output logic [PORTS-1:0][DATA_W-1:0] out_data,
  output logic [PORTS-1:0][ADDR_W-1:0] out_tag
);
  localparam int ELEMS = PORTS / 2;

  for (genvar e = 0; e < ELEMS; e++) begin : g_elem
    localparam int LO = lo_line(e, BIT);
    localparam int HI = LO + (1 << BIT);

    logic [1:0]             e_rdy, e_vld;
    logic [1:0][DATA_W-1:0] e_data;
    logic [1:0][ADDR_W-1:0] e_tag;

    bfly_elem #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .BIT    (BIT)
    ) u_elem (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   ({in_vld[HI], in_vld[LO]}),
      .in_rdy   (e_rdy),
      .in_data  ({in_data[HI], in_data[LO]}),
      .in_tag   ({in_tag[HI], in_tag[LO]}),
      .out_vld  (e_vld),
      .out_rdy  ({out_rdy[HI], out_rdy[LO]}),
      .out_data (e_data),
      .out_tag  (e_tag)
    );

    assign in_rdy[LO]   = e_rdy[0];
    assign in_rdy[HI]   = e_rdy[1];
    assign out_vld[LO]  = e_vld[0];
    assign out_vld[HI]  = e_vld[1];
    assign out_data[LO] = e_data[0];
    assign out_data[HI] = e_data[1];
    assign out_tag[LO]  = e_tag[0];
    assign out_tag[HI]  = e_tag[1];
  end
endmodule

// File: rtl/bfly_net.sv
module bfly_net #(
  parameter int PORTS  = 16,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(PORTS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PORTS-1:0]             in_valid,
  output logic [PORTS-1:0]             in_ready,
  input  logic [PORTS-1:0][ADDR_W-1:0] in_dst,
  input  logic [PORTS-1:0][DATA_W-1:0] in_data,
  output logic [PORTS-1:0]             out_valid,
  input  logic [PORTS-1:0]             out_ready,
  output logic [PORTS-1:0][DATA_W-1:0] out_data,
  output logic [PORTS-1:0][ADDR_W-1:0] out_src
);
  localparam int STAGES = ADDR_W;

  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic [STAGES:0][PORTS-1:0]             vld, rdy;
  logic [STAGES:0][PORTS-1:0][DATA_W-1:0] data;
  logic [STAGES:0][PORTS-1:0][ADDR_W-1:0] tag;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign tag[0][p] = in_dst[p] ^ ADDR_W'(p);
    assign out_src[p] = tag[STAGES][p] ^ ADDR_W'(p);
  end

  assign vld[0]      = in_valid;
  assign data[0]     = in_data;
  assign in_ready    = rdy[0] & {PORTS{core_rst_n}};
  assign out_valid   = vld[STAGES];
  assign out_data    = data[STAGES];
  assign rdy[STAGES] = out_ready;

  for (genvar s = 0; s < STAGES; s++) begin : g_col
    bfly_stage #(
      .PORTS  (PORTS),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .BIT    (STAGES - 1 - s)
    ) u_col (
      .clk      (clk),
      .rst_n    (core_rst_n),
      .in_vld   (vld[s]),
      .in_rdy   (rdy[s]),
      .in_data  (data[s]),
      .in_tag   (tag[s]),
      .out_vld  (vld[s+1]),
      .out_rdy  (rdy[s+1]),
      .out_data (data[s+1]),
      .out_tag  (tag[s+1])
    );
  end
endmodule

// File: rtl/bfly_net_chk.sv
module bfly_net_chk #(
  parameter int PORTS  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [PORTS-1:0]             in_valid,
  input logic [PORTS-1:0]             in_ready,
  input logic [PORTS-1:0]             out_valid,
  input logic [PORTS-1:0]             out_ready,
  input logic [PORTS-1:0][DATA_W-1:0] out_data,
  input logic [PORTS-1:0][ADDR_W-1:0] out_src
);
  localparam int CAP = PORTS * ADDR_W;

  logic [31:0] inflight;
  logic [1:0]  age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight <= '0;
      age      <= '0;
    end else begin
      inflight <= inflight + 32'($countones(in_valid & in_ready))
                           - 32'($countones(out_valid & out_ready));
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  // R10: occupancy bounded by the register count
  p_capacity_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 32'(CAP));

  // R10: never more outputs valid than flits taken in
  p_conserve_r10: assert property (@(posedge clk) disable iff (!rst_n)
    32'($countones(out_valid)) <= inflight);

  for (genvar p = 0; p < PORTS; p++) begin : g_chk
    // R7: stalled output keeps its flit
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[p] && !out_ready[p] |=>
        out_valid[p] && $stable(out_data[p]) && $stable(out_src[p]));

    // R5: ready only drops for a reason
    p_ready_reason_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) && !in_ready[p] |-> (in_valid != '0) || (inflight != '0));
  end
endmodule

bind bfly_net bfly_net_chk #(
  .PORTS  (PORTS),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_src   (out_src)
);

// File: tb/bfly_net_tb.sv
module bfly_net_tb;
  localparam int PORTS  = 16;
  localparam int DATA_W = 16;
  localparam int ADDR_W = $clog2(PORTS);
  localparam int STAGES = ADDR_W;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PORTS-1:0]             iv = '0;
  logic [PORTS-1:0]             in_ready;
  logic [PORTS-1:0][ADDR_W-1:0] idst = '0;
  logic [PORTS-1:0][DATA_W-1:0] idat = '0;
  logic [PORTS-1:0]             out_valid;
  logic [PORTS-1:0]             ordy = '1;
  logic [PORTS-1:0][DATA_W-1:0] out_data;
  logic [PORTS-1:0][ADDR_W-1:0] out_src;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfly_net #(.PORTS(PORTS), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(iv), .in_ready(in_ready), .in_dst(idst), .in_data(idat),
    .out_valid(out_valid), .out_ready(ordy), .out_data(out_data), .out_src(out_src)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, serial = 1;
  int exp_t = -100, exp_p = 0;
  bit lat_on = 0, model_on = 0, done = 0;
  logic [PORTS-1:0] acc, rdy_s;
  int unsigned q_data[PORTS][PORTS][$];
  int          q_t[PORTS][PORTS][$];

  task automatic note(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pending();
    int n = 0;
    for (int s = 0; s < PORTS; s++)
      for (int d = 0; d < PORTS; d++) n += q_data[s][d].size();
    return n;
  endfunction

  task automatic offer(input int p, input int d);
    iv[p]   = 1'b1;
    idst[p] = ADDR_W'(d);
    idat[p] = DATA_W'(serial);
    serial++;
  endtask

  task automatic tick();
    logic [PORTS-1:0] exp_ov;
    #1;
    rdy_s = in_ready;
    for (int p = 0; p < PORTS; p++) begin
      acc[p] = iv[p] & in_ready[p];
      if (acc[p]) begin
        q_data[p][idst[p]].push_back(int'(idat[p]));
        q_t[p][idst[p]].push_back(cyc);
        if (model_on) begin exp_t = cyc; exp_p = int'(idst[p]); end
      end
    end
    if (model_on) begin
      exp_ov = (cyc == exp_t + STAGES) ? (PORTS'(1) << exp_p) : '0;
      note(out_valid == exp_ov, "R4", "out_valid vector", out_valid, exp_ov);
    end
    for (int p = 0; p < PORTS; p++) begin
      if (out_valid[p] && ordy[p]) begin
        int s = int'(out_src[p]);
        if (q_data[s][p].size() == 0) begin
          note(0, "R9", "unexpected flit at output", p, -1);
        end else begin
          int unsigned d = q_data[s][p].pop_front();
          int t = q_t[s][p].pop_front();
          note(int'(out_data[p]) == int'(d), "R2", "payload", out_data[p], d);
          if (lat_on) note(cyc - t == STAGES, "R4", "latency", cyc - t, STAGES);
        end
      end
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    for (int p = 0; p < PORTS; p++) if (acc[p]) iv[p] = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    int first;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1: idle state after reset
    note(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
    note(in_ready == '1, "R1", "in_ready after reset", in_ready, '1);
    @(negedge clk);

    // R5 / R6: clash at first column, lower line wins first
    lat_on = 1;
    offer(0, 0); offer(PORTS/2, 0);
    tick();
    note(rdy_s[0] == 1'b1, "R5", "winner ready", rdy_s[0], 1);
    note(rdy_s[PORTS/2] == 1'b0, "R5", "loser ready", rdy_s[PORTS/2], 0);
    tick();
    note(acc[PORTS/2] == 1'b1, "R5", "loser taken next cycle", acc[PORTS/2], 1);
    repeat (STAGES + 3) tick();
    // R6: second clash goes to upper line
    offer(0, 0); offer(PORTS/2, 0);
    tick();
    note(rdy_s[PORTS/2] == 1'b1, "R6", "upper line priority", rdy_s[PORTS/2], 1);
    note(rdy_s[0] == 1'b0, "R6", "lower line held", rdy_s[0], 0);
    repeat (STAGES + 3) tick();

    // R3: adjacent sources crossing to swapped outputs do not clash
    offer(0, 1); offer(1, 0);
    tick();
    note(rdy_s[1:0] == 2'b11, "R3", "both accepted", rdy_s[1:0], 3);
    repeat (STAGES + 2) tick();
    note(pending() == 0, "R3", "delivered", pending(), 0);

    // R4 / R2: isolated single-source traffic with per-cycle model
    model_on = 1;
    for (int k = 0; k < 200; k++) begin
      offer(int'($urandom_range(PORTS-1)), int'($urandom_range(PORTS-1)));
      tick();
      repeat (STAGES + 1) tick();
    end
    model_on = 0;
    note(pending() == 0, "R4", "isolated flits left", pending(), 0);

    // R8 / R7: stalled output fills one path
    lat_on = 0;
    ordy[0] = 1'b0;
    cnt = 0;
    first = serial;
    for (int k = 0; k < STAGES + 4; k++) begin
      if (!iv[0]) offer(3, 0);
      tick();
      if (acc[3]) cnt++;
    end
    note(cnt == STAGES, "R8", "flits on stalled path", cnt, STAGES);
    note(rdy_s[3] == 1'b0, "R8", "ready when path full", rdy_s[3], 0);
    #1;
    note(out_valid[0] == 1'b1, "R7", "stalled valid", out_valid[0], 1);
    note(int'(out_data[0]) == first, "R7", "stalled payload", out_data[0], first);
    iv[3] = 1'b0;
    ordy[0] = 1'b1;
    repeat (STAGES + 4) tick();
    note(pending() == 0, "R8", "stalled flits drained in order", pending(), 0);

    // R9: concurrent random traffic with random stalls
    for (int k = 0; k < 3000; k++) begin
      for (int p = 0; p < PORTS; p++) begin
        if (!iv[p] && ($urandom_range(2) == 0)) offer(p, int'($urandom_range(PORTS-1)));
        ordy[p] = ($urandom_range(3) != 0);
      end
      tick();
    end
    iv = '0;
    ordy = '1;
    repeat (STAGES * 4 + 8) tick();
    note(pending() == 0, "R9", "flits lost", pending(), 0);
    #1;
    note(out_valid == '0, "R9", "extra flits after drain", out_valid, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule